// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block runs an external analog-to-digital converter on behalf of software. A small register set holds an enable bit, a run bit, two interrupt enables, a scan mode and a first/last channel pair. Once enabled, a conversion scan may be launched by writing the run bit or by pulsing a hardware trigger input. The sequencer then issues one start pulse per channel on the converter handshake, waits for the converter's done strobe, stores the returned sample and moves to the next channel. Channel numbers wrap modulo the channel count.

In one-shot mode the scan halts after the last channel and the run bit drops by itself. In continuous mode the scan restarts at the first channel until software writes 0 to the run bit. Each stored sample raises a completion flag. A sample stored while the previous one is still unread also raises an overrun flag. Each flag has its own interrupt enable, and both flags are cleared by writing 1 to them.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, every control, configuration and status bit reads 0 and `irq` is low.
- R2: While the enable bit (CTRL bit 0) is 0, software and hardware triggers are ignored and the run bit (CTRL bit 1) reads 0. Clearing the enable bit during a scan aborts it and the block issues no further start pulses.
- R3: A write to CTRL (address 0) with bits 0 and 1 both set, made while the block is enabled and idle, starts a scan. The run bit reads 1 for as long as the scan lasts.
- R4: A one-cycle pulse on `hw_trig` while the block is enabled and idle starts a scan and sets the run bit without any software write.
- R5: A one-shot scan (MODE address 1, bit 0 = 0) issues exactly one `conv_start` pulse per channel, in order from FIRST (address 2) to LAST (address 3), incrementing modulo NUM_CH. It then drops the run bit.
- R6: In continuous mode (MODE bit 0 = 1), the scan restarts at FIRST after LAST completes. Writing CTRL with bit 1 = 0 stops it at once, and no further start pulses follow.
- R7: Each completed conversion sets the completion flag (STAT address 4, bit 0). Writing 1 to that bit clears it.
- R8: A sample stored while the previous sample has not been read from RESULT (address 5, with `bus_rd`) sets the overrun flag (STAT bit 1). The flag is cleared by writing 1 to it. RESULT returns the most recent sample.
- R9: `irq` is high exactly when the completion flag is set with CTRL bit 4 set, or when the overrun flag is set with CTRL bit 5 set.
- R10: Writes to MODE, FIRST and LAST are ignored while the enable bit is 1.
- R11: Triggers that arrive while a scan is running are ignored and do not restart the channel sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on RESULT only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for `bus_addr` (combinational) |
| hw_trig | input | 1 | Hardware conversion trigger |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | CH_W | Channel being converted |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | DATA_W | Converter sample, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_CH = 8 and DATA_W = 10, against a converter model that answers three cycles after each start pulse. With eight channels, a range of FIRST = 6 and LAST = 1 crosses the wrap from channel 7 to channel 0 within a short scan. This makes the modulo step, the continuous restart and the stop-mid-scan path all reachable in a few hundred cycles. The three-cycle latency leaves room to pulse a second trigger while a conversion is pending.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} step_state_t;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_MODE   = 3'd1;
  localparam logic [2:0] A_FIRST  = 3'd2;
  localparam logic [2:0] A_LAST   = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;
  localparam logic [2:0] A_RESULT = 3'd5;

  // next channel in the scan, wrapping at the channel count
  function automatic int unsigned ch_step(int unsigned ch, int unsigned n);
    return (ch + 1 >= n) ? 0 : ch + 1;
  endfunction

  // interrupt request from the two flag/enable pairs
  function automatic logic irq_of(logic done_f, logic done_ie, logic ovf_f, logic ovf_ie);
    return (done_f & done_ie) | (ovf_f & ovf_ie);
  endfunction

endpackage

// File: rtl/adc_seq_regs.sv
`timescale 1ns/1ps
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  parameter int BUS_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              conv_fin,
  input  logic [DATA_W-1:0] conv_result,
  output logic              en,
  output logic              cont,
  output logic [CH_W-1:0]   first_ch,
  output logic [CH_W-1:0]   last_ch,
  output logic              sw_start,
  output logic              sw_stop,
  output logic              irq
);

  logic done_ie, ovf_ie, done_f, ovf_f, unread_q;
  logic [DATA_W-1:0] result_q;

  wire wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  wire wr_mode   = bus_wr && (bus_addr == A_MODE);
  wire wr_first  = bus_wr && (bus_addr == A_FIRST);
  wire wr_last   = bus_wr && (bus_addr == A_LAST);
  wire wr_stat   = bus_wr && (bus_addr == A_STAT);
  wire rd_result = bus_rd && (bus_addr == A_RESULT);
  wire overrun   = conv_fin && unread_q && !rd_result;

  assign sw_start = wr_ctrl && bus_wdata[0] && bus_wdata[1] && en;
  assign sw_stop  = wr_ctrl && !bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; done_ie <= 1'b0; ovf_ie <= 1'b0;
      cont <= 1'b0; first_ch <= '0; last_ch <= '0;
      done_f <= 1'b0; ovf_f <= 1'b0; unread_q <= 1'b0; result_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en      <= bus_wdata[0];
        done_ie <= bus_wdata[4];
        ovf_ie  <= bus_wdata[5];
      end
      if (!en) begin
        if (wr_mode)  cont     <= bus_wdata[0];
        if (wr_first) first_ch <= bus_wdata[CH_W-1:0];
        if (wr_last)  last_ch  <= bus_wdata[CH_W-1:0];
      end
      done_f   <= conv_fin | (done_f & !(wr_stat && bus_wdata[0]));
      ovf_f    <= overrun  | (ovf_f  & !(wr_stat && bus_wdata[1]));
      unread_q <= conv_fin | (unread_q & !rd_result);
      if (conv_fin) result_q <= conv_result;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = BUS_W'({ovf_ie, done_ie, 2'b00, busy & en, en});
      A_MODE:   bus_rdata = BUS_W'(cont);
      A_FIRST:  bus_rdata = BUS_W'(first_ch);
      A_LAST:   bus_rdata = BUS_W'(last_ch);
      A_STAT:   bus_rdata = BUS_W'({ovf_f, done_f});
      A_RESULT: bus_rdata = BUS_W'(result_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = irq_of(done_f, done_ie, ovf_f, ovf_ie);

  // R10: configuration frozen across any edge where the block was enabled
  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(first_ch) && $stable(last_ch) && $stable(cont)));

  // R7: each completion raises the flag
  p_done_on_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fin |=> done_f);

  // R7: write-one-to-clear without a competing completion
  p_done_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !conv_fin) |=> !done_f);

  // R8: storing over an unread sample raises the overrun flag
  p_ovf_on_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fin && unread_q && !rd_result) |=> ovf_f);

endmodule

// File: rtl/adc_seq_step.sv
`timescale 1ns/1ps
module adc_seq_step
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cont,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  input  logic            sw_start,
  input  logic            sw_stop,
  input  logic            hw_trig,
  input  logic            conv_done,
  output logic            busy,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            conv_fin
);

  step_state_t st_q;
  logic [CH_W-1:0] ch_q;

  wire is_last     = (ch_q == last_ch);
  wire trig_accept = en && (st_q == ST_IDLE) && (sw_start || hw_trig);
  wire scan_end    = conv_fin && is_last && !cont;
  wire [CH_W-1:0] ch_next = CH_W'(ch_step(int'(unsigned'(ch_q)), NUM_CH));

  assign conv_fin   = (st_q == ST_WAIT) && conv_done;
  assign busy       = (st_q != ST_IDLE);
  assign conv_start = (st_q == ST_LAUNCH);
  assign conv_ch    = ch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
    end else if (!en || sw_stop) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (trig_accept) begin
          st_q <= ST_LAUNCH;
          ch_q <= first_ch;
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (!is_last) begin
            ch_q <= ch_next;
            st_q <= ST_LAUNCH;
          end else if (cont) begin
            ch_q <= first_ch;
            st_q <= ST_LAUNCH;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5: a start strobe lasts one cycle
  p_launch_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5: one-shot scan halts after the last channel
  p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_end && en && !sw_stop) |=> !busy);

  // R6: continuous scan relaunches on the first channel
  p_cont_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fin && is_last && cont && en && !sw_stop) |=> (conv_start && conv_ch == $past(first_ch)));

  // R2: disabled for two samples means no scan in progress
  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> !busy);

  // R11: a pending conversion keeps its channel whatever triggers arrive
  p_no_retrigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && !conv_done && en && !sw_stop) |=> $stable(conv_ch));

endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  parameter int BUS_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              hw_trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq
);

  logic en, cont, sw_start, sw_stop, busy, conv_fin;
  logic [CH_W-1:0] first_ch, last_ch;

  adc_seq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .conv_fin(conv_fin), .conv_result(conv_data),
    .en(en), .cont(cont), .first_ch(first_ch), .last_ch(last_ch),
    .sw_start(sw_start), .sw_stop(sw_stop), .irq(irq)
  );

  adc_seq_step #(.NUM_CH(NUM_CH)) step_i (
    .clk(clk), .rst_n(rst_n),
    .en(en), .cont(cont), .first_ch(first_ch), .last_ch(last_ch),
    .sw_start(sw_start), .sw_stop(sw_stop), .hw_trig(hw_trig),
    .conv_done(conv_done), .busy(busy), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_fin(conv_fin)
  );

  // R9: request never raised with both sources disabled in the register
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[5:4] == 2'b00 && bus_addr == A_CTRL) |-> !irq);

endmodule

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;

  localparam int NUM_CH = 8;
  localparam int DATA_W = 10;
  localparam int BUS_W  = 16;
  localparam int CH_W   = 3;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, hw_trig = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [BUS_W-1:0] bus_wdata = '0;
  logic [BUS_W-1:0] bus_rdata;
  logic conv_start, conv_done, irq;
  logic [CH_W-1:0] conv_ch;
  logic [DATA_W-1:0] conv_data;

  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  bit allow_extra = 1'b0;
  int starts_seen = 0;
  int pend_cnt = 0, pend_ch = 0;

  always #2 clk = ~clk;

  adc_seq_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_trig(hw_trig), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
  );

  function automatic int model_val(int ch);
    return (ch * 97 + 13) % 1024;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // converter model: fixed latency after each start strobe
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          conv_done = 1'b1;
          conv_data = DATA_W'(model_val(pend_ch));
        end
      end
      if (conv_start) begin
        pend_ch  = int'(conv_ch);
        pend_cnt = LAT;
      end
    end
  end

  // scoreboard monitor: every start strobe must match the next expected channel
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        starts_seen++;
        if (exp_q.size() > 0) begin
          check("R5 channel order", int'(conv_ch), exp_q.pop_front());
        end else if (!allow_extra) begin
          check("R11 unexpected start", 1, 0);
        end
      end
    end
  end

  task automatic bus_write(logic [2:0] a, int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = BUS_W'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic read_result(output int v);
    @(negedge clk);
    bus_addr = 3'd5; bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_hw();
    @(negedge clk);
    hw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0;
  endtask

  task automatic push_range(int f, int l);
    int c = f;
    forever begin
      exp_q.push_back(c);
      if (c == l) break;
      c = (c + 1) % NUM_CH;
    end
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 1000; i++) begin
      bus_read(3'd0, v);
      if (v[1] == 1'b0) return;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int v, s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(3'd0, v); check("R1 ctrl", v, 0);
    bus_read(3'd1, v); check("R1 mode", v, 0);
    bus_read(3'd4, v); check("R1 stat", v, 0);
    check("R1 irq", int'(irq), 0);

    // R2: triggers ignored while disabled
    bus_write(3'd0, 'h02);
    pulse_hw();
    repeat (10) @(negedge clk);
    check("R2 no start", starts_seen, 0);
    bus_read(3'd0, v); check("R2 ctrl", v, 0);

    // R10: config writable only while disabled
    bus_write(3'd2, 2); bus_write(3'd3, 5); bus_write(3'd1, 0);
    bus_read(3'd2, v); check("R10 first", v, 2);
    bus_write(3'd0, 'h01);
    bus_write(3'd2, 7);
    bus_write(3'd1, 1);
    bus_read(3'd2, v); check("R10 first locked", v, 2);
    bus_read(3'd1, v); check("R10 mode locked", v, 0);

    // R3/R5: one-shot software scan 2..5
    push_range(2, 5);
    bus_write(3'd0, 'h03);
    bus_read(3'd0, v); check("R3 busy", v, 'h03);
    wait_idle();
    check("R5 all channels", exp_q.size(), 0);
    bus_read(3'd0, v); check("R5 idle", v, 'h01);
    bus_read(3'd4, v); check("R7 R8 stat", v, 3);
    check("R9 irq masked", int'(irq), 0);
    read_result(v); check("R8 result", v, model_val(5));

    // R9/R7: interrupt from each source, cleared by W1C
    bus_write(3'd0, 'h11); check("R9 done irq", int'(irq), 1);
    bus_write(3'd4, 'h01);
    bus_read(3'd4, v); check("R7 w1c", v, 2);
    check("R9 irq low", int'(irq), 0);
    bus_write(3'd0, 'h21); check("R9 ovf irq", int'(irq), 1);
    bus_write(3'd4, 'h02);
    check("R9 irq cleared", int'(irq), 0);
    bus_read(3'd4, v); check("R8 w1c", v, 0);

    // R8: a read between samples prevents overrun
    bus_write(3'd0, 'h00);
    bus_write(3'd2, 3); bus_write(3'd3, 3);
    bus_write(3'd0, 'h01);
    push_range(3, 3); bus_write(3'd0, 'h03); wait_idle();
    read_result(v); check("R8 result ch3", v, model_val(3));
    push_range(3, 3); bus_write(3'd0, 'h03); wait_idle();
    bus_read(3'd4, v); check("R8 no overrun", v, 1);

    // R4/R11: hardware trigger, second trigger while busy ignored
    s0 = starts_seen;
    push_range(3, 3);
    pulse_hw();
    bus_read(3'd0, v); check("R4 hw busy", v, 'h03);
    pulse_hw();
    wait_idle();
    repeat (10) @(negedge clk);
    check("R11 single start", starts_seen - s0, 1);

    // R6: continuous scan across the wrap, then stop
    bus_write(3'd0, 'h00);
    bus_write(3'd1, 1); bus_write(3'd2, 6); bus_write(3'd3, 1);
    bus_write(3'd0, 'h01);
    push_range(6, 1); push_range(6, 1);
    bus_write(3'd0, 'h03);
    for (int g = 0; g < 5000 && exp_q.size() > 0; g++) @(negedge clk);
    check("R6 two rounds", exp_q.size(), 0);
    allow_extra = 1'b1;
    bus_write(3'd0, 'h01);
    bus_read(3'd0, v); check("R6 stopped", v, 'h01);
    s0 = starts_seen;
    repeat (20) @(negedge clk);
    check("R6 no restart", starts_seen - s0, 0);

    // R2: disabling aborts a running scan
    bus_write(3'd0, 'h00);
    bus_write(3'd1, 0); bus_write(3'd2, 0); bus_write(3'd3, 7);
    bus_write(3'd0, 'h01);
    bus_write(3'd0, 'h03);
    repeat (5) @(negedge clk);
    bus_write(3'd0, 'h00);
    bus_read(3'd0, v); check("R2 abort", v, 0);
    s0 = starts_seen;
    repeat (20) @(negedge clk);
    check("R2 abort quiet", starts_seen - s0, 0);
    bus_write(3'd0, 'h01);
    bus_read(3'd0, v); check("R2 stays idle", v, 'h01);
    allow_extra = 1'b0;

    finish_run();
  end

endmodule